// File: doc/BRIEF.md
# Timer Interrupt Status Flag Unit

This block keeps the pending-interrupt flags of an advanced-control timer. The timer core sends it single-cycle event strobes: compare hits, captures, counter wraps, software update requests, trigger edges, gate start/stop, commutation and a break level. Each flag follows its own set rule. Software clears flags through a write port that uses write-0-to-clear semantics.

Each flag also drives an interrupt request line. The line is the flag ANDed with its enable bit, and it is registered. Capture flags clear themselves when software reads the capture register of that channel. The update flag is gated by the repetition count and by the update-disable and update-source controls. The break flag cannot be cleared while the break level is still present.

Top module: `tim_irq_flags`

## Requirements
- R1: After reset all flags, all of `status_o` and all of `irq_o` are 0. Bits of `status_o` above the flag bits always read 0.
- R2: The break flag (bit 7) is set in every cycle where `brk_active_i` is 1. A software clear is ignored while `brk_active_i` is 1, and it takes effect when `brk_active_i` is 0.
- R3: When `gated_mode_i` is 0, `trig_edge_i` sets the trigger flag (bit 6) and `gate_toggle_i` has no effect. When `gated_mode_i` is 1, `gate_toggle_i` sets it and `trig_edge_i` has no effect.
- R4: `com_evt_i` sets the commutation flag (bit 5).
- R5: A channel c in output mode (`ch_out_mode_i[c]`=1) has its flag at bit c+1. That flag is set by `cmp_hit_i[c]`. When `cmp_above_i[c]` is 1, the flag is also set on `ovf_i` if `cnt_mode_i` is 0 (up) or 2 (center), and on `unf_i` if `cnt_mode_i` is 1 (down).
- R6: A channel in input mode has its flag set by `cap_evt_i[c]` and cleared by `cap_rd_i[c]`. In output mode, `cap_rd_i[c]` has no effect.
- R7: `ovf_i` or `unf_i` sets the update flag (bit 0) only when `rep_zero_i` is 1 and `udis_i` is 0.
- R8: `ug_req_i` or `trig_reinit_i` sets the update flag only when `urs_i` and `udis_i` are both 0.
- R9: With `wr_en_i`=1, each bit of `wr_data_i` that is 0 clears the matching flag, and each bit that is 1 leaves it unchanged. The bit map is: update 0, channels 1 to 4, commutation 5, trigger 6, break 7.
- R10: When a set event and a clear hit the same flag in the same cycle, the flag is set.
- R11: `irq_o[i]` equals the value of flag i AND `irq_en_i[i]` one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_active_i | input | 1 | Break input is at its active level |
| trig_edge_i | input | 1 | Active trigger edge strobe |
| gated_mode_i | input | 1 | Slave controller is in gated mode |
| gate_toggle_i | input | 1 | Counter started or stopped by the gate |
| com_evt_i | input | 1 | Commutation update strobe |
| ch_out_mode_i | input | 4 | Per channel: 1 for output, 0 for input |
| cmp_hit_i | input | 4 | Counter equals compare value |
| cmp_above_i | input | 4 | Compare value is greater than the reload value |
| cap_evt_i | input | 4 | Capture strobe |
| cap_rd_i | input | 4 | Capture register read strobe |
| ovf_i | input | 1 | Counter overflow strobe |
| unf_i | input | 1 | Counter underflow strobe |
| cnt_mode_i | input | 2 | 0 up, 1 down, 2 center |
| rep_zero_i | input | 1 | Repetition counter is 0 |
| ug_req_i | input | 1 | Software update-generation strobe |
| trig_reinit_i | input | 1 | Trigger-driven counter reinit strobe |
| udis_i | input | 1 | Update disable |
| urs_i | input | 1 | Update source restricted to wraps |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Write data, 0 clears |
| irq_en_i | input | 8 | Per-flag interrupt enable |
| status_o | output | 16 | Flag word, upper bits 0 |
| irq_o | output | 8 | Registered interrupt requests |

## Verification
The assertions assume that the event inputs are single-cycle strobes that are synchronous to `clk_i`. They also assume `cnt_mode_i` never takes the value 3. The random stimulus draws `cnt_mode_i` only from 0, 1 and 2. It drives every input at the falling edge, so each input holds steady across the edge that samples it. Directed sequences first cover each set and clear rule on its own. Random traffic then mixes events with writes in the same cycle, and a behavioural reference model checks the result.

// File: rtl/tim_flag_pkg.sv
package tim_flag_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_FLAG = NUM_CH + 4;
  localparam int UPD_BIT  = 0;
  localparam int CH_LSB   = 1;
  localparam int COM_BIT  = NUM_CH + 1;
  localparam int TRG_BIT  = NUM_CH + 2;
  localparam int BRK_BIT  = NUM_CH + 3;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_CENTER = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/tim_flag_events.sv
module tim_flag_events
  import tim_flag_pkg::*;
#(
  parameter int NCH = NUM_CH,
  localparam int NF = NCH + 4
) (
  input  logic           brk_active_i,
  input  logic           trig_edge_i,
  input  logic           gated_mode_i,
  input  logic           gate_toggle_i,
  input  logic           com_evt_i,
  input  logic [NCH-1:0] ch_out_mode_i,
  input  logic [NCH-1:0] cmp_hit_i,
  input  logic [NCH-1:0] cmp_above_i,
  input  logic [NCH-1:0] cap_evt_i,
  input  logic [NCH-1:0] cap_rd_i,
  input  logic           ovf_i,
  input  logic           unf_i,
  input  logic [1:0]     cnt_mode_i,
  input  logic           rep_zero_i,
  input  logic           ug_req_i,
  input  logic           trig_reinit_i,
  input  logic           udis_i,
  input  logic           urs_i,
  input  logic           wr_en_i,
  input  logic [NF-1:0]  wr_data_i,
  output logic [NF-1:0]  set_o,
  output logic [NF-1:0]  clr_o
);
  logic          wrap_hit;
  logic [NF-1:0] sw_clr;

  // overflow qualifies in up/center, underflow in down
  assign wrap_hit = (cnt_mode_i == CNT_DOWN) ? unf_i : ovf_i;
  assign sw_clr   = {NF{wr_en_i}} & ~wr_data_i;

  assign set_o[NCH+1] = com_evt_i;
  assign set_o[NCH+2] = gated_mode_i ? gate_toggle_i : trig_edge_i;
  assign set_o[NCH+3] = brk_active_i;
  assign set_o[0]     = (!udis_i && (ovf_i || unf_i) && rep_zero_i) ||
                        (!udis_i && !urs_i && (ug_req_i || trig_reinit_i));

  assign clr_o[0]     = sw_clr[0];
  assign clr_o[NCH+1] = sw_clr[NCH+1];
  assign clr_o[NCH+2] = sw_clr[NCH+2];
  assign clr_o[NCH+3] = sw_clr[NCH+3] && !brk_active_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign set_o[c+1] = ch_out_mode_i[c] ? (cmp_hit_i[c] || (cmp_above_i[c] && wrap_hit))
                                         : cap_evt_i[c];
    assign clr_o[c+1] = sw_clr[c+1] || (!ch_out_mode_i[c] && cap_rd_i[c]);
  end
endmodule

// File: rtl/tim_flag_cell.sv
module tim_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r9_hold_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tim_flag_irq.sv
module tim_flag_irq #(
  parameter int NF = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= flags_i & en_i;
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    a_r11_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[i] && en_i[i]) |=> irq_o[i]);
    a_r11_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flags_i[i] |=> !irq_o[i]);
  end
endmodule

// File: rtl/tim_irq_flags.sv
module tim_irq_flags
  import tim_flag_pkg::*;
#(
  parameter int NCH      = NUM_CH,
  parameter int STATUS_W = 16,
  localparam int NF      = NCH + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                brk_active_i,
  input  logic                trig_edge_i,
  input  logic                gated_mode_i,
  input  logic                gate_toggle_i,
  input  logic                com_evt_i,
  input  logic [NCH-1:0]      ch_out_mode_i,
  input  logic [NCH-1:0]      cmp_hit_i,
  input  logic [NCH-1:0]      cmp_above_i,
  input  logic [NCH-1:0]      cap_evt_i,
  input  logic [NCH-1:0]      cap_rd_i,
  input  logic                ovf_i,
  input  logic                unf_i,
  input  logic [1:0]          cnt_mode_i,
  input  logic                rep_zero_i,
  input  logic                ug_req_i,
  input  logic                trig_reinit_i,
  input  logic                udis_i,
  input  logic                urs_i,
  input  logic                wr_en_i,
  input  logic [NF-1:0]       wr_data_i,
  input  logic [NF-1:0]       irq_en_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [NF-1:0]       irq_o
);
  logic [NF-1:0] set_v, clr_v, flags;

  tim_flag_events #(.NCH(NCH)) u_events (
    .brk_active_i, .trig_edge_i, .gated_mode_i, .gate_toggle_i, .com_evt_i,
    .ch_out_mode_i, .cmp_hit_i, .cmp_above_i, .cap_evt_i, .cap_rd_i,
    .ovf_i, .unf_i, .cnt_mode_i, .rep_zero_i, .ug_req_i, .trig_reinit_i,
    .udis_i, .urs_i, .wr_en_i, .wr_data_i,
    .set_o(set_v), .clr_o(clr_v)
  );

  for (genvar i = 0; i < NF; i++) begin : g_flag
    tim_flag_cell u_cell (
      .clk_i, .rst_ni, .set_i(set_v[i]), .clr_i(clr_v[i]), .flag_o(flags[i])
    );
  end

  tim_flag_irq #(.NF(NF)) u_irq (
    .clk_i, .rst_ni, .flags_i(flags), .en_i(irq_en_i), .irq_o
  );

  assign status_o = {{(STATUS_W-NF){1'b0}}, flags};

  a_r2_brk_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_active_i |=> status_o[NCH+3]);
  a_r7_udis_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udis_i && !status_o[0]) |=> !status_o[0]);
  a_r8_urs_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urs_i && !ovf_i && !unf_i && !status_o[0]) |=> !status_o[0]);
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o >> NF) == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_cap_chk
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_out_mode_i[c] && cap_rd_i[c] && !cap_evt_i[c]) |=> !status_o[c+1]);
  end
endmodule

// File: tb/sim_tim_irq_flags.sv
module sim_tim_irq_flags;
  localparam int NCH = 4;
  localparam int NF  = 8;

  logic clk = 0, rst_n = 0;
  logic brk = 0, tedge = 0, gmode = 0, gtog = 0, com = 0;
  logic [NCH-1:0] omode = '1, hit = 0, above = 0, cap = 0, crd = 0;
  logic ovf = 0, unf = 0, repz = 0, ug = 0, treinit = 0, udis = 0, urs = 0;
  logic [1:0] cmode = 0;
  logic wr = 0;
  logic [NF-1:0] wdat = '1, en = 0;
  logic [15:0] status;
  logic [NF-1:0] irq;

  int errors = 0, checks = 0;
  bit [NF-1:0] m_flag = 0, m_irq = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  tim_irq_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .brk_active_i(brk), .trig_edge_i(tedge),
    .gated_mode_i(gmode), .gate_toggle_i(gtog), .com_evt_i(com),
    .ch_out_mode_i(omode), .cmp_hit_i(hit), .cmp_above_i(above),
    .cap_evt_i(cap), .cap_rd_i(crd), .ovf_i(ovf), .unf_i(unf),
    .cnt_mode_i(cmode), .rep_zero_i(repz), .ug_req_i(ug),
    .trig_reinit_i(treinit), .udis_i(udis), .urs_i(urs), .wr_en_i(wr),
    .wr_data_i(wdat), .irq_en_i(en), .status_o(status), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (rst_n && model_on) begin
      bit [NF-1:0] nf;
      nf = m_flag;
      for (int b = 0; b < NF; b++)
        if (wr && !wdat[b] && !(b == 7 && brk)) nf[b] = 0;
      for (int c = 0; c < NCH; c++)
        if (!omode[c] && crd[c]) nf[c+1] = 0;
      if (brk) nf[7] = 1;
      if ((gmode && gtog) || (!gmode && tedge)) nf[6] = 1;
      if (com) nf[5] = 1;
      for (int c = 0; c < NCH; c++) begin
        if (omode[c]) begin
          if (hit[c]) nf[c+1] = 1;
          if (above[c] && ((cmode == 1) ? unf : ovf)) nf[c+1] = 1;
        end else if (cap[c]) nf[c+1] = 1;
      end
      if (!udis && repz && (ovf || unf)) nf[0] = 1;
      if (!udis && !urs && (ug || treinit)) nf[0] = 1;
      m_irq  <= m_flag & en;
      m_flag <= nf;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check("R9 R10 model status", status, {8'h00, m_flag});
      check("R11 model irq", irq, m_irq);
    end
  end

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic idle();
    brk = 0; tedge = 0; gtog = 0; com = 0; hit = 0; above = 0; cap = 0; crd = 0;
    ovf = 0; unf = 0; ug = 0; treinit = 0; wr = 0; wdat = '1;
  endtask
  task automatic clear_all();
    idle(); wr = 1; wdat = 0; step(); idle();
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 0);
    check("R1 reset irq", irq, 0);
    rst_n = 1; model_on = 1;
    @(negedge clk);
    check("R1 idle after reset", status, 0);

    // R2 break
    brk = 1; step();
    check("R2 break set", status[7], 1);
    wr = 1; wdat = 8'h7F; step();
    check("R2 clear blocked while active", status[7], 1);
    brk = 0; step();
    check("R2 clear when inactive", status[7], 0);
    idle();

    // R3 trigger
    gmode = 0; tedge = 1; step(); idle();
    check("R3 edge sets in non-gated", status[6], 1);
    clear_all();
    gtog = 1; step(); idle();
    check("R3 gate toggle ignored non-gated", status[6], 0);
    gmode = 1; tedge = 1; step(); idle();
    check("R3 edge ignored in gated", status[6], 0);
    gtog = 1; step(); idle();
    check("R3 gate toggle sets in gated", status[6], 1);
    gmode = 0; clear_all();

    // R4 commutation
    com = 1; step(); idle();
    check("R4 com set", status[5], 1);
    clear_all();

    // R5 output compare
    omode = '1; hit[0] = 1; step(); idle();
    check("R5 compare hit", status[1], 1);
    clear_all();
    above[0] = 1; cmode = 1; ovf = 1; step(); idle();
    check("R5 down mode ignores overflow", status[1], 0);
    above[0] = 1; unf = 1; step(); idle();
    check("R5 down mode underflow", status[1], 1);
    clear_all();
    above[0] = 1; cmode = 2; ovf = 1; step(); idle();
    check("R5 center mode overflow", status[1], 1);
    cmode = 0; clear_all();

    // R6 capture
    omode[1] = 0; cap[1] = 1; step(); idle();
    check("R6 capture set", status[2], 1);
    crd[1] = 1; step(); idle();
    check("R6 read clears", status[2], 0);
    omode[1] = 1; hit[1] = 1; step(); idle();
    crd[1] = 1; step(); idle();
    check("R6 read ignored in output mode", status[2], 1);
    clear_all();

    // R7 update from wraps
    ovf = 1; repz = 0; step(); idle();
    check("R7 no set rep nonzero", status[0], 0);
    repz = 1; udis = 1; unf = 1; step(); idle();
    check("R7 no set with udis", status[0], 0);
    udis = 0; ovf = 1; step(); idle();
    check("R7 set on wrap", status[0], 1);
    repz = 0; clear_all();

    // R8 update from requests
    urs = 1; ug = 1; step(); idle();
    check("R8 urs blocks request", status[0], 0);
    urs = 0; udis = 1; treinit = 1; step(); idle();
    check("R8 udis blocks reinit", status[0], 0);
    udis = 0; ug = 1; step(); idle();
    check("R8 request sets", status[0], 1);
    clear_all();
    treinit = 1; step(); idle();
    check("R8 reinit sets", status[0], 1);

    // R9 write-0-to-clear
    com = 1; omode[1] = 0; cap[1] = 1; step(); idle();
    wr = 1; wdat = 8'hFF; step(); idle();
    check("R9 ones keep flags", status, 16'h0025);
    wr = 1; wdat = 8'hFB; step(); idle();
    check("R9 zero clears bit2 only", status, 16'h0021);
    omode = '1; clear_all();

    // R10 set beats clear
    com = 1; wr = 1; wdat = 0; step(); idle();
    check("R10 set wins", status, 16'h0020);
    clear_all();

    // R11 irq latency
    en = 8'h20; com = 1; step(); idle();
    check("R11 irq not yet", irq[5], 0);
    step();
    check("R11 irq asserted", irq[5], 1);
    wr = 1; wdat = 8'hDF; step(); idle();
    check("R11 irq still high after clear", irq[5], 1);
    step();
    check("R11 irq dropped", irq[5], 0);

    // random mixed traffic, model checks each cycle
    for (int n = 0; n < 3000; n++) begin
      brk = ($urandom % 16) == 0; tedge = $urandom; gmode = ($urandom % 8) == 0;
      gtog = $urandom; com = ($urandom % 4) == 0; omode = $urandom;
      hit = $urandom; above = $urandom; cap = $urandom; crd = $urandom;
      ovf = ($urandom % 4) == 0; unf = ($urandom % 4) == 0; cmode = 2'($urandom % 3);
      repz = $urandom; ug = ($urandom % 4) == 0; treinit = ($urandom % 4) == 0;
      udis = ($urandom % 4) == 0; urs = $urandom; wr = $urandom;
      wdat = $urandom; en = $urandom;
      step();
    end
    idle();
    step();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule